// File: doc/BRIEF.md
# Interrupt Controller with Return Stack

This block arbitrates three overflow sources of a small processor core: a time-base counter and two timers. It also holds the core's four-level return-address stack for a 13-bit program counter. The enables, the global enable and the pending request flags sit together in one 8-bit control register, which software writes and reads through a simple register port. On each sample strobe the controller decides whether to take a request. When it takes one, it pushes the current PC onto the stack, clears the request flag it serviced and the global enable, and presents a vector address with a one-cycle take strobe.

The instruction decoder drives call, return and return-from-interrupt strobes. A call pushes the current PC. Either kind of return pops the stack and presents the saved address. Only a return-from-interrupt turns the global enable back on. The stack is four circular slots with a saturating occupancy count. While all four levels are in use, requests are recorded but not taken. A call made on a full stack overwrites the oldest entry.

Top module: `irq_ret_stack`

## Requirements
- R1: After reset, reg_rdata reads 0x00, take_irq is 0 and ret_addr is 0x000.
- R2: The control register maps bit0 = global enable, bits 3:1 = enables for time base, timer 0 and timer 1, and bits 6:4 = the matching request flags. A write stores bits 6:0. Bit 7 always reads 0. reg_rdata shows the register state one cycle after the edge that changed it.
- R3: A pulse on src_tick[i] sets flag bit 4+i. A flag stays set until it is serviced or a write clears it. A pulse in the same cycle as a write wins over the written value.
- R4: A request is taken only in a cycle where phase2 is high, the global enable is set, some flag has its enable set, fewer than 4 entries are on the stack, and reg_we, call_stb, ret_stb and reti_stb are all low. take_irq is high for exactly the following cycle.
- R5: Among enabled pending flags, the time base wins over timer 0, and timer 0 wins over timer 1. Their vectors are 0x004, 0x008 and 0x00C, valid while take_irq is high.
- R6: Taking a request pushes pc_now, clears only the serviced flag and clears the global enable.
- R7: With 4 entries on the stack, a request stays pending without being taken. It is taken at the first sample strobe after a return frees a level.
- R8: A return strobe presents the most recently pushed address on ret_addr in the next cycle. reti_stb also sets the global enable; ret_stb leaves it unchanged.
- R9: A call on a full stack overwrites the oldest entry and occupancy stays 4. Four returns after five calls give back the 5th, 4th, 3rd and 2nd addresses.
- R10: A return on an empty stack presents the slot the pointer steps back to and keeps occupancy at 0, so three later calls still leave room for an interrupt.
- R11: Pending requests are never taken in a cycle where phase2 is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_tick | input | 3 | Overflow pulses: [0] time base, [1] timer 0, [2] timer 1 |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 7 | Control register write data, bits 6:0 |
| reg_rdata | output | 8 | Control register read data (registered) |
| phase2 | input | 1 | Sample strobe, one cycle per instruction cycle |
| pc_now | input | 13 | Current program counter, pushed on call or take |
| call_stb | input | 1 | Subroutine call strobe |
| ret_stb | input | 1 | Plain return strobe |
| reti_stb | input | 1 | Return-from-interrupt strobe |
| take_irq | output | 1 | One-cycle strobe: a request was taken |
| vector | output | 13 | Vector address of the taken request |
| ret_addr | output | 13 | Address popped by the last return |

## Verification
The hardest case to reach is the boundary of the stack. That covers a request that must wait while all four levels are full, a call that wraps onto the oldest slot, and a return issued on an empty stack. Only the ports can show the occupancy count. The bench fills the stack through call strobes and confirms the full state by showing that an armed, enabled request is refused. It then frees one level with a return and sees the request taken at the next strobe. For the empty case, the bench pops past empty and then makes three calls. If the count had wrapped below zero, the next request would be blocked; the bench shows it is accepted instead.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC = 3;

  typedef struct packed {
    logic [NSRC-1:0] flag;
    logic [NSRC-1:0] en;
    logic            gie;
  } ctrl_t;
endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NSRC     = 3,
  parameter int PC_W     = 13,
  parameter int VEC_STEP = 4
) (
  input  logic [NSRC-1:0] pend,
  output logic [NSRC-1:0] grant,
  output logic            any,
  output logic [PC_W-1:0] vec
);
  genvar i;
  generate
    for (i = 0; i < NSRC; i++) begin : g_pri
      if (i == 0) begin : g_first
        assign grant[i] = pend[i];
      end else begin : g_rest
        assign grant[i] = pend[i] & ~(|pend[i-1:0]);
      end
    end
  endgenerate

  assign any = |pend;

  always_comb begin
    vec = '0;
    for (int k = 0; k < NSRC; k++) begin
      if (grant[k]) vec = vec | PC_W'((k + 1) * VEC_STEP);
    end
  end
endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
  import irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [6:0]      wdata,
  input  logic [NSRC-1:0] tick,
  input  logic            take,
  input  logic [NSRC-1:0] grant,
  input  logic            reti,
  output ctrl_t           q
);
  ctrl_t q_n;

  always_comb begin
    q_n = q;
    if (we) q_n = ctrl_t'(wdata);
    if (take) begin
      q_n.flag = q_n.flag & ~grant;
      q_n.gie  = 1'b0;
    end
    if (reti) q_n.gie = 1'b1;
    q_n.flag = q_n.flag | tick;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q_n;
  end
endmodule

// File: rtl/irq_ret_stack_mem.sv
module irq_ret_stack_mem #(
  parameter int W     = 13,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic                       pop,
  input  logic [W-1:0]               din,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] occ
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slot [DEPTH];
  logic [PW-1:0] sp;
  logic [PW-1:0] sp_dn;

  assign sp_dn = (sp == '0) ? PW'(DEPTH - 1) : sp - 1'b1;
  assign dout  = slot[sp_dn];

  always_ff @(posedge clk) begin
    if (push && !pop) slot[sp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp  <= '0;
      occ <= '0;
    end else if (pop) begin
      sp  <= sp_dn;
      occ <= (occ == '0) ? '0 : occ - 1'b1;
    end else if (push) begin
      sp  <= (sp == PW'(DEPTH - 1)) ? '0 : sp + 1'b1;
      occ <= (occ == CW'(DEPTH)) ? occ : occ + 1'b1;
    end
  end
endmodule

// File: rtl/irq_ret_stack.sv
module irq_ret_stack
  import irq_pkg::*;
#(
  parameter int PC_W     = 13,
  parameter int DEPTH    = 4,
  parameter int VEC_STEP = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2:0]      src_tick,
  input  logic            reg_we,
  input  logic [6:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  input  logic            phase2,
  input  logic [PC_W-1:0] pc_now,
  input  logic            call_stb,
  input  logic            ret_stb,
  input  logic            reti_stb,
  output logic            take_irq,
  output logic [PC_W-1:0] vector,
  output logic [PC_W-1:0] ret_addr
);
  localparam int CW = $clog2(DEPTH + 1);

  ctrl_t           ctrl;
  logic [NSRC-1:0] grant;
  logic            any_pend;
  logic [PC_W-1:0] vec_c;
  logic [PC_W-1:0] top_c;
  logic [CW-1:0]   occ;
  logic            take_now;
  logic            pop;
  logic            push;

  assign pop      = ret_stb | reti_stb;
  assign take_now = phase2 & ctrl.gie & any_pend & (occ < CW'(DEPTH))
                    & ~reg_we & ~call_stb & ~pop;
  assign push     = take_now | (call_stb & ~pop);

  irq_arbiter #(.NSRC(NSRC), .PC_W(PC_W), .VEC_STEP(VEC_STEP)) u_arb (
    .pend  (ctrl.flag & ctrl.en),
    .grant (grant),
    .any   (any_pend),
    .vec   (vec_c)
  );

  irq_ctrl_reg u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .we    (reg_we),
    .wdata (reg_wdata),
    .tick  (src_tick),
    .take  (take_now),
    .grant (grant),
    .reti  (reti_stb),
    .q     (ctrl)
  );

  irq_ret_stack_mem #(.W(PC_W), .DEPTH(DEPTH)) u_stack (
    .clk  (clk),
    .rst  (rst),
    .push (push),
    .pop  (pop),
    .din  (pc_now),
    .dout (top_c),
    .occ  (occ)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      take_irq  <= 1'b0;
      vector    <= '0;
      ret_addr  <= '0;
      reg_rdata <= '0;
    end else begin
      take_irq  <= take_now;
      reg_rdata <= {1'b0, ctrl};
      if (take_now) vector   <= vec_c;
      if (pop)      ret_addr <= top_c;
    end
  end
endmodule

// File: rtl/irq_ret_stack_chk.sv
module irq_ret_stack_chk #(
  parameter int PC_W  = 13,
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            phase2,
  input logic            take_irq,
  input logic [PC_W-1:0] vector,
  input logic [7:0]      reg_rdata,
  input logic [CW-1:0]   occ
);
  assert_take_on_strobe_R11: assert property (@(posedge clk) disable iff (rst)
    take_irq |-> $past(phase2));

  assert_take_single_R4: assert property (@(posedge clk) disable iff (rst)
    take_irq |=> !take_irq);

  assert_vector_legal_R5: assert property (@(posedge clk) disable iff (rst)
    take_irq |-> (vector == PC_W'(4) || vector == PC_W'(8) || vector == PC_W'(12)));

  assert_bit7_zero_R2: assert property (@(posedge clk) disable iff (rst)
    !reg_rdata[7]);

  assert_gie_cleared_R6: assert property (@(posedge clk) disable iff (rst)
    take_irq |=> !reg_rdata[0]);

  assert_not_when_full_R7: assert property (@(posedge clk) disable iff (rst)
    take_irq |-> ($past(occ) < CW'(DEPTH)));

  assert_occ_saturates_R9: assert property (@(posedge clk) disable iff (rst)
    occ <= CW'(DEPTH));
endmodule

bind irq_ret_stack irq_ret_stack_chk #(.PC_W(PC_W), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .phase2    (phase2),
  .take_irq  (take_irq),
  .vector    (vector),
  .reg_rdata (reg_rdata),
  .occ       (u_stack.occ)
);

// File: tb/test_irq_ret_stack.sv
module test_irq_ret_stack;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  src_tick;
  logic        reg_we;
  logic [6:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        phase2;
  logic [12:0] pc_now;
  logic        call_stb, ret_stb, reti_stb;
  logic        take_irq;
  logic [12:0] vector;
  logic [12:0] ret_addr;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  irq_ret_stack i_irq_ret_stack (
    .clk(clk), .rst(rst), .src_tick(src_tick), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .phase2(phase2),
    .pc_now(pc_now), .call_stb(call_stb), .ret_stb(ret_stb),
    .reti_stb(reti_stb), .take_irq(take_irq), .vector(vector),
    .ret_addr(ret_addr)
  );

  // entry: {ctrl[6:0], tick[2:0], take, vec[12:0], pc[12:0]}
  localparam int NV = 8;
  localparam logic [36:0] TBL [NV] = '{
    {7'h0F, 3'b111, 1'b1, 13'h004, 13'h0123},
    {7'h0F, 3'b110, 1'b1, 13'h008, 13'h0456},
    {7'h0F, 3'b100, 1'b1, 13'h00C, 13'h1789},
    {7'h0D, 3'b011, 1'b1, 13'h008, 13'h0ABC},
    {7'h0E, 3'b111, 1'b0, 13'h000, 13'h0011},
    {7'h09, 3'b011, 1'b0, 13'h000, 13'h0022},
    {7'h07, 3'b100, 1'b0, 13'h000, 13'h0033},
    {7'h09, 3'b111, 1'b1, 13'h00C, 13'h1FFF}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic wr(input logic [6:0] v);
    reg_we = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic tick(input logic [2:0] t);
    src_tick = t;
    @(negedge clk);
    src_tick = '0;
  endtask

  task automatic sample(input logic [12:0] pc);
    phase2 = 1'b1; pc_now = pc;
    @(negedge clk);
    phase2 = 1'b0;
  endtask

  task automatic call(input logic [12:0] pc);
    call_stb = 1'b1; pc_now = pc;
    @(negedge clk);
    call_stb = 1'b0;
  endtask

  task automatic ret(input bit from_irq);
    if (from_irq) reti_stb = 1'b1; else ret_stb = 1'b1;
    @(negedge clk);
    reti_stb = 1'b0; ret_stb = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    src_tick = '0; reg_we = 0; reg_wdata = '0; phase2 = 0; pc_now = '0;
    call_stb = 0; ret_stb = 0; reti_stb = 0;
    @(negedge clk);
    do_reset();

    // R1 reset state
    check("R1 rdata", reg_rdata, 0);
    check("R1 take", take_irq, 0);
    check("R1 ret_addr", ret_addr, 0);

    // Table walk: R4, R5, R8
    for (int e = 0; e < NV; e++) begin
      wr(TBL[e][36:30]);
      tick(TBL[e][29:27]);
      sample(TBL[e][12:0]);
      check("R4 take", take_irq, TBL[e][26]);
      if (TBL[e][26]) begin
        check("R5 vector", vector, TBL[e][25:13]);
        ret(1);
        check("R8 reti addr", ret_addr, TBL[e][12:0]);
      end
    end

    // R2 layout and bit 7
    do_reset();
    wr(7'h7F); idle();
    check("R2 readback", reg_rdata, 8'h7F);
    wr(7'h00); idle();
    check("R2 clear", reg_rdata, 8'h00);

    // R3 tick wins over same-cycle write, flag sticky
    reg_we = 1'b1; reg_wdata = 7'h00; src_tick = 3'b010;
    @(negedge clk);
    reg_we = 1'b0; src_tick = '0;
    repeat (3) idle();
    check("R3 sticky flag", reg_rdata, 8'h20);

    // R11 no take without strobe; R6 selective clear
    do_reset();
    wr(7'h03);
    tick(3'b011);
    repeat (4) begin
      idle();
      check("R11 no take off strobe", take_irq, 0);
    end
    sample(13'h0444);
    check("R11 take on strobe", take_irq, 1);
    check("R5 tb vector", vector, 13'h004);
    idle();
    check("R6 flags/gie after take", reg_rdata, 8'h22);
    ret(1);
    check("R6 pushed pc", ret_addr, 13'h0444);

    // R7 full stack holds request
    do_reset();
    for (int k = 0; k < 4; k++) call(13'h100 + 13'(k));
    wr(7'h03);
    tick(3'b001);
    sample(13'h0555);
    check("R7 blocked when full", take_irq, 0);
    idle();
    check("R7 flag kept", reg_rdata, 8'h13);
    ret(0);
    check("R7 ret addr", ret_addr, 13'h103);
    sample(13'h0555);
    check("R7 taken after return", take_irq, 1);
    ret(1);
    check("R7 reti addr", ret_addr, 13'h0555);

    // R9 overflow drops oldest, R10 empty pop
    do_reset();
    for (int k = 1; k <= 5; k++) call(13'h200 + 13'(k));
    for (int k = 5; k >= 2; k--) begin
      ret(0);
      check("R9 pop order", ret_addr, 13'h200 + 13'(k));
    end
    ret(0);
    check("R10 empty pop slot", ret_addr, 13'h205);
    for (int k = 1; k <= 3; k++) call(13'h300 + 13'(k));
    wr(7'h03);
    tick(3'b001);
    sample(13'h0777);
    check("R10 occupancy stayed 0", take_irq, 1);

    // R8 ret vs reti on global enable
    do_reset();
    call(13'h050);
    ret(0);
    check("R8 ret addr", ret_addr, 13'h050);
    idle();
    check("R8 ret leaves gie", reg_rdata, 8'h00);
    call(13'h060);
    ret(1);
    check("R8 reti addr", ret_addr, 13'h060);
    idle();
    check("R8 reti sets gie", reg_rdata, 8'h01);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule